// File: doc/BRIEF.md
# PCM Frame Timing and Sample Buffering Controller

This block paces the PCM side of a voice transcoder. From a 2 MHz clock it counts out a fixed 125 µs frame (8 kHz) and marks the last cycle of each frame with a one-cycle strobe. At each such boundary it moves samples in both directions. The sample that software or DMA left in the input holding register goes to the working register that feeds the converter. The newest converted sample is latched into the output holding register, where the bus can read it.

Each frame boundary also raises one service request. If the PCM interrupt enable is set, the request is a sticky interrupt flag, which software clears by writing 1. If it is clear, the request is a DMA request, which stays asserted until it is acknowledged. The block tracks whether each holding register was serviced during the frame. It reports an input underrun when no new sample was written, in which case the previous sample is used again. It reports an output overrun when the sample was replaced without having been read.

The compressed side runs at half the PCM rate, so the block marks every second frame boundary for it. It also merges the almost-empty and almost-full levels of the compressed-data FIFOs into a single gated interrupt request. The filter engine and the codecs live outside this block.

Top module: `pcm_frame_timer`

## Requirements
- R1: `frameTick` is high for exactly one cycle in every `FRAME_CYCLES` (default 250) cycles. After reset is released, the first pulse comes in cycle index `FRAME_CYCLES-1`, counting the first cycle out of reset as index 0.
- R2: On the clock edge that ends a `frameTick` cycle, `workIn` takes the value held in the input holding register. At all other edges `workIn` keeps its value. A write made during the `frameTick` cycle does not go into that transfer; it is kept for the following frame.
- R3: On the clock edge that ends a `frameTick` cycle, `outRdData` takes the value of `convOut`. It then holds that value until the next frame boundary.
- R4: At a frame boundary, `pcmIrq` is set if `pcmIntEn` is 1. If `pcmIntEn` is 0, `dmaReq` is set instead. The boundary never sets the other request.
- R5: `dmaReq` stays high until a cycle with `dmaAck` high, and it falls at the edge that ends that cycle. If the acknowledge arrives in a cycle where a frame sets a new DMA request, the new request wins.
- R6: `pcmIrq` stays high until a cycle with `irqClr` high, and it falls at the edge that ends that cycle. If the clear arrives in a cycle where a frame sets the flag, the set wins.
- R7: At each frame boundary, `underrun` is updated. It becomes 1 if `inWrEn` was not high in any cycle since the previous boundary edge, excluding the `frameTick` cycle itself, and 0 otherwise. When no write was made, `workIn` receives the last value that was written again.
- R8: At each frame boundary, `overrun` is updated. It becomes 1 if the sample that is being replaced was never read with `outRdEn` since it was loaded, where a read in the `frameTick` cycle counts. The sample held since reset counts as read.
- R9: `cvsdTick` is high only in `frameTick` cycles, and only in every second one, starting with the second pulse after reset.
- R10: `cvsdIrq` equals `cvsdIntEn` ANDed with the OR of the four `cvsdLevelFlags` bits, delayed by one clock.
- R11: While `rstN` is 0, every output is 0, and the sample registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcmIntEn | input | 1 | 1 = interrupt per frame, 0 = DMA request per frame |
| inWrEn | input | 1 | Write strobe for the input holding register |
| inWrData | input | SAMPLE_W | Sample written into the input holding register |
| outRdEn | input | 1 | Read strobe marking the output holding register as consumed |
| outRdData | output | SAMPLE_W | Output holding register contents |
| workIn | output | SAMPLE_W | Working sample presented to the converter |
| convOut | input | SAMPLE_W | Newest sample produced by the converter |
| dmaAck | input | 1 | DMA acknowledge; clears `dmaReq` |
| irqClr | input | 1 | Write-1 clear of `pcmIrq` |
| cvsdIntEn | input | 1 | Enable for the FIFO level interrupt |
| cvsdLevelFlags | input | 4 | FIFO level flags: receive almost-empty, receive almost-full, transmit almost-empty, transmit almost-full |
| frameTick | output | 1 | One-cycle frame boundary strobe |
| cvsdTick | output | 1 | Boundary strobe for the half-rate compressed side |
| dmaReq | output | 1 | Per-frame DMA request |
| pcmIrq | output | 1 | Sticky per-frame interrupt flag |
| cvsdIrq | output | 1 | Registered FIFO level interrupt request |
| underrun | output | 1 | No input sample was written in the frame just ended |
| overrun | output | 1 | The output sample was replaced without being read |

## Verification
`frameTick` and `cvsdTick` are decoded combinationally from the frame counter, so they are due in the same cycle that the counter reaches its last value. Every registered result is due one edge later: the sample transfers, the request set and clear, and both flags all change on the edge that closes the strobe cycle or the cycle with the acknowledge or clear. `cvsdIrq` follows its inputs after one edge. The bench model applies each edge's update, using the inputs that were driven for that cycle, and the outputs are compared at the falling edge. That way, each comparison sees exactly the state that the last rising edge produced. The stimulus places writes, reads, acknowledges and clears both in the middle of a frame and in the strobe cycle itself, so that the same-cycle priorities are exercised.

// File: rtl/pcm_frame_pkg.sv
package pcm_frame_pkg;

  // Strobes issued by the control path to the sample datapath
  typedef struct packed {
    logic frameSwap;  // last cycle of a frame: move samples at this edge
    logic inLoad;     // input holding register written this cycle
    logic outTake;    // output holding register read this cycle
  } pcmStrobes_t;

  localparam int unsigned LEVEL_FLAG_W = 4;

endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_frame_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 250,
  parameter int unsigned FLAG_W       = LEVEL_FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcmIntEn,
  input  logic              inWrEn,
  input  logic              outRdEn,
  input  logic              dmaAck,
  input  logic              irqClr,
  input  logic              cvsdIntEn,
  input  logic [FLAG_W-1:0] cvsdLevelFlags,
  output pcmStrobes_t       strobes,
  output logic              frameTick,
  output logic              cvsdTick,
  output logic              dmaReq,
  output logic              pcmIrq,
  output logic              cvsdIrq
);

  localparam int unsigned CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] frameCnt;
  logic             atLast;
  logic             halfSel;
  logic             levelAny;

  assign atLast = (frameCnt == LAST_CNT);

  // Frame counter: wraps after the terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (atLast) begin
      frameCnt <= '0;
    end else begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  // Half-rate phase for the compressed side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfSel <= 1'b0;
    end else if (atLast) begin
      halfSel <= ~halfSel;
    end
  end

  // Per-frame service request routed to DMA or the interrupt flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaReq <= 1'b0;
    end else if (atLast && !pcmIntEn) begin
      dmaReq <= 1'b1;
    end else if (dmaAck) begin
      dmaReq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcmIrq <= 1'b0;
    end else if (atLast && pcmIntEn) begin
      pcmIrq <= 1'b1;
    end else if (irqClr) begin
      pcmIrq <= 1'b0;
    end
  end

  // FIFO level flags merged and gated, one register stage
  assign levelAny = |cvsdLevelFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cvsdIrq <= 1'b0;
    end else begin
      cvsdIrq <= cvsdIntEn & levelAny;
    end
  end

  assign frameTick         = atLast;
  assign cvsdTick          = atLast & halfSel;
  assign strobes.frameSwap = atLast;
  assign strobes.inLoad    = inWrEn;
  assign strobes.outTake   = outRdEn;

endmodule

// File: rtl/pcm_frame_dp.sv
module pcm_frame_dp
  import pcm_frame_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  pcmStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] inWrData,
  input  logic [SAMPLE_W-1:0] convOut,
  output logic [SAMPLE_W-1:0] workIn,
  output logic [SAMPLE_W-1:0] outRdData,
  output logic                underrun,
  output logic                overrun
);

  logic [SAMPLE_W-1:0] inHold;
  logic [SAMPLE_W-1:0] outHold;
  logic                inFilled;
  logic                outConsumed;

  // Input holding register: written any cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inHold <= '0;
    end else if (strobes.inLoad) begin
      inHold <= inWrData;
    end
  end

  // Working and output registers move only at the frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workIn  <= '0;
      outHold <= '0;
    end else if (strobes.frameSwap) begin
      workIn  <= inHold;
      outHold <= convOut;
    end
  end

  // Service tracking for both holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFilled    <= 1'b0;
      outConsumed <= 1'b1;
      underrun    <= 1'b0;
      overrun     <= 1'b0;
    end else if (strobes.frameSwap) begin
      underrun    <= ~inFilled;
      overrun     <= ~(outConsumed | strobes.outTake);
      inFilled    <= strobes.inLoad;
      outConsumed <= 1'b0;
    end else begin
      if (strobes.inLoad) begin
        inFilled <= 1'b1;
      end
      if (strobes.outTake) begin
        outConsumed <= 1'b1;
      end
    end
  end

  assign outRdData = outHold;

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_frame_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 250,
  parameter int unsigned SAMPLE_W     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pcmIntEn,
  input  logic                    inWrEn,
  input  logic [SAMPLE_W-1:0]     inWrData,
  input  logic                    outRdEn,
  output logic [SAMPLE_W-1:0]     outRdData,
  output logic [SAMPLE_W-1:0]     workIn,
  input  logic [SAMPLE_W-1:0]     convOut,
  input  logic                    dmaAck,
  input  logic                    irqClr,
  input  logic                    cvsdIntEn,
  input  logic [LEVEL_FLAG_W-1:0] cvsdLevelFlags,
  output logic                    frameTick,
  output logic                    cvsdTick,
  output logic                    dmaReq,
  output logic                    pcmIrq,
  output logic                    cvsdIrq,
  output logic                    underrun,
  output logic                    overrun
);

  pcmStrobes_t strobes;

  pcm_frame_ctrl #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .FLAG_W      (LEVEL_FLAG_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .pcmIntEn      (pcmIntEn),
    .inWrEn        (inWrEn),
    .outRdEn       (outRdEn),
    .dmaAck        (dmaAck),
    .irqClr        (irqClr),
    .cvsdIntEn     (cvsdIntEn),
    .cvsdLevelFlags(cvsdLevelFlags),
    .strobes       (strobes),
    .frameTick     (frameTick),
    .cvsdTick      (cvsdTick),
    .dmaReq        (dmaReq),
    .pcmIrq        (pcmIrq),
    .cvsdIrq       (cvsdIrq)
  );

  pcm_frame_dp #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inWrData (inWrData),
    .convOut  (convOut),
    .workIn   (workIn),
    .outRdData(outRdData),
    .underrun (underrun),
    .overrun  (overrun)
  );

endmodule

// File: rtl/pcm_frame_checker.sv
module pcm_frame_checker
  import pcm_frame_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 250,
  parameter int unsigned SAMPLE_W     = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    pcmIntEn,
  input logic                    inWrEn,
  input logic [SAMPLE_W-1:0]     inWrData,
  input logic                    outRdEn,
  input logic [SAMPLE_W-1:0]     outRdData,
  input logic [SAMPLE_W-1:0]     workIn,
  input logic [SAMPLE_W-1:0]     convOut,
  input logic                    dmaAck,
  input logic                    irqClr,
  input logic                    cvsdIntEn,
  input logic [LEVEL_FLAG_W-1:0] cvsdLevelFlags,
  input logic                    frameTick,
  input logic                    cvsdTick,
  input logic                    dmaReq,
  input logic                    pcmIrq,
  input logic                    cvsdIrq,
  input logic                    underrun,
  input logic                    overrun
);

  localparam int unsigned SW = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) + 1 : 2;

  // Independent count of cycles since reset or since the last strobe
  logic [SW-1:0] sinceTick;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceTick <= '0;
    end else if (frameTick) begin
      sinceTick <= '0;
    end else begin
      sinceTick <= sinceTick + 1'b1;
    end
  end

  p_tick_on_time_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceTick == SW'(FRAME_CYCLES - 1)) |-> frameTick);
  p_tick_not_early_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |-> (sinceTick == SW'(FRAME_CYCLES - 1)));
  p_work_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(workIn));
  p_out_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> (outRdData == $past(convOut)));
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(outRdData));
  p_irq_route_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && pcmIntEn) |=> pcmIrq);
  p_dma_route_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !pcmIntEn) |=> dmaReq);
  p_dma_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck) |=> dmaReq);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pcmIrq && !irqClr) |=> pcmIrq);
  p_read_no_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && outRdEn) |=> !overrun);
  p_half_rate_r9: assert property (@(posedge clk) disable iff (!rstN)
    cvsdTick |-> frameTick);
  p_level_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cvsdIrq) |-> $past(cvsdIntEn));

endmodule

bind pcm_frame_timer pcm_frame_checker #(
  .FRAME_CYCLES(FRAME_CYCLES),
  .SAMPLE_W    (SAMPLE_W)
) u_chk (.*);

// File: tb/tb_pcm_frame_timer.sv
`timescale 1ns/1ps
module tb_pcm_frame_timer;

  localparam int FRAMES = 250;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pcmIntEn = 1'b0;
  logic          inWrEn = 1'b0;
  logic [SW-1:0] inWrData = '0;
  logic          outRdEn = 1'b0;
  logic [SW-1:0] outRdData;
  logic [SW-1:0] workIn;
  logic [SW-1:0] convOut = '0;
  logic          dmaAck = 1'b0;
  logic          irqClr = 1'b0;
  logic          cvsdIntEn = 1'b0;
  logic [3:0]    cvsdLevelFlags = '0;
  logic          frameTick, cvsdTick, dmaReq, pcmIrq, cvsdIrq, underrun, overrun;

  pcm_frame_timer #(.FRAME_CYCLES(FRAMES), .SAMPLE_W(SW)) dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference state
  int mCnt = 0;
  int mFrame = 0;
  bit mHalf = 0, mDma = 0, mIrq = 0, mCvsd = 0, mUnder = 0, mOver = 0;
  bit mFilled = 0, mRead = 1;
  int mInHold = 0, mWork = 0, mOutHold = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mHalf = 0; mDma = 0; mIrq = 0; mCvsd = 0; mUnder = 0; mOver = 0;
      mFilled = 0; mRead = 1; mInHold = 0; mWork = 0; mOutHold = 0; mFrame = 0;
    end else begin
      bit tick;
      tick = (mCnt == FRAMES - 1);
      mCvsd = cvsdIntEn && (cvsdLevelFlags != 0);
      if (tick) begin
        mWork = mInHold;
        mOutHold = convOut;
        mUnder = !mFilled;
        mOver = !(mRead || outRdEn);
        mFilled = inWrEn;
        mRead = 0;
        mHalf = !mHalf;
        mFrame++;
        if (pcmIntEn) begin
          mIrq = 1;
          if (dmaAck) mDma = 0;
        end else begin
          mDma = 1;
          if (irqClr) mIrq = 0;
        end
        mCnt = 0;
      end else begin
        if (inWrEn) mFilled = 1;
        if (outRdEn) mRead = 1;
        if (dmaAck) mDma = 0;
        if (irqClr) mIrq = 0;
        mCnt++;
      end
      if (inWrEn) mInHold = inWrData;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit eTick;
    eTick = (mCnt == FRAMES - 1);
    chk(frameTick == eTick, "R1 frameTick", frameTick, eTick);
    chk(workIn == SW'(mWork), "R2 workIn", workIn, mWork);
    chk(outRdData == SW'(mOutHold), "R3 outRdData", outRdData, mOutHold);
    chk(dmaReq == mDma, "R4 R5 dmaReq", dmaReq, mDma);
    chk(pcmIrq == mIrq, "R4 R6 pcmIrq", pcmIrq, mIrq);
    chk(underrun == mUnder, "R7 underrun", underrun, mUnder);
    chk(overrun == mOver, "R8 overrun", overrun, mOver);
    chk(cvsdTick == (eTick && mHalf), "R9 cvsdTick", cvsdTick, eTick && mHalf);
    chk(cvsdIrq == mCvsd, "R10 cvsdIrq", cvsdIrq, mCvsd);
  endtask

  // Stimulus chosen from the frame index and position within the frame
  task automatic driveCycle();
    int f, p;
    f = mFrame; p = mCnt;
    inWrEn   = ((f % 3 != 2) && p == 50) || ((f % 4 == 1) && p == FRAMES - 1);
    inWrData = SW'($urandom);
    outRdEn  = ((f % 3 != 1) && p == 100) || ((f % 5 == 0) && p == FRAMES - 1);
    convOut  = SW'($urandom);
    pcmIntEn = ((f / 4) % 2) == 1;
    dmaAck   = ((f % 2 == 0) && p == 30) || (f == 6 && p == FRAMES - 1) || (f == 9 && p == FRAMES - 1);
    irqClr   = ((f % 2 == 1) && p == 40) || (f == 5 && p == FRAMES - 1) || (f == 13 && p == FRAMES - 1);
    cvsdIntEn = (f % 3) != 0;
    cvsdLevelFlags = ($urandom % 8 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frameTick == 0 && cvsdTick == 0 && dmaReq == 0 && pcmIrq == 0 && cvsdIrq == 0,
        "R11 reset strobes", {frameTick, cvsdTick, dmaReq, pcmIrq, cvsdIrq}, 0);
    chk(workIn == 0 && outRdData == 0 && underrun == 0 && overrun == 0,
        "R11 reset samples", workIn ^ outRdData, 0);
    rstN = 1'b1;
    for (int c = 0; c < 16 * FRAMES; c++) begin
      @(negedge clk);
      compareAll();
      driveCycle();
    end
    done = 1;
  end

  initial begin
    for (int w = 0; w < 100000 && !done; w++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule